// File: doc/BRIEF.md
# Processor-Port Memory Bank Decoder

This block sits between a small 8-bit CPU and the memories and peripherals of a 64 KiB home-computer address map. It owns a two-register processor port: a direction register at address 0x0000 and an output register at address 0x0001. Three bits of the port choose which of the upper windows show ROM, RAM or the I/O page. Every cycle the block decodes the CPU address against that mapping, raises the select of the target device, hands each device its masked register offset, and steers the returning read data onto a single read bus.

The effective mapping value is built from the port as `(~direction) | output`, so a bit configured as input reads as 1 and the default after reset turns on the two program ROMs and the I/O page. Inside the I/O page, address bits 11:8 choose one of five device windows: video, sound, a 4-bit color memory, and two timer devices. The rest of the page is open bus, except its last byte, which holds an internal value that flips on every read. Writes aimed at a window that reads as ROM land in the RAM below it.

The RAM and ROM arrays and the peripherals are outside the block. A system without defined open-bus data ties `floatData` to any value.

Top module: `port_bank_decoder`

## Requirements
- R1: On reset the direction and output registers clear to 0x00, so the effective value `m = (~dir | out) & 3'b111` is 7 from the first cycle after reset.
- R2: Addresses 0xA000-0xBFFF select the BASIC ROM when m[1:0] == 2'b11 and select RAM otherwise.
- R3: Addresses 0xE000-0xFFFF select the KERNAL ROM when m[1] is 1 and select RAM otherwise.
- R4: For 0xD000-0xDFFF: when m[1:0] is 0, the window is RAM. Otherwise m[2] == 0 selects the character ROM and m[2] == 1 selects the I/O page.
- R5: Addresses 0x0000 and 0x0001 select the port. Addresses 0x0002-0x9FFF and 0xC000-0xCFFF always select RAM.
- R6: A write (`wrEn`) to a window that reads as BASIC, character or KERNAL ROM asserts `ramCs` and none of `basicCs`, `charCs` or `kernalCs`. ROM selects assert only on reads. `romOffset` is addr[12:0] for BASIC and KERNAL and addr[11:0] for the character ROM.
- R7: In the I/O page, addr[11:8] chooses the device. Values 0-3 select video with `devOffset` = addr & 0x3F. Values 4-7 select sound with addr & 0x1F. Values 8-B select the color memory with `colorOffset` = addr[9:0]. 0xC selects timer 1 and 0xD selects timer 2, each with addr & 0x0F. Values E-F are open and return `floatData`.
- R8: A color read returns {floatData[7:4], colorRdData[3:0]}. A color write presents wrData[3:0] on `colorWrData`.
- R9: Each read of 0xDFFF in the I/O page inverts an internal byte and returns the inverted value in the same cycle. The byte resets to 0x55. A read of any other open address leaves the byte unchanged and returns `floatData`.
- R10: A read of 0x0000 returns the direction register. A read of 0x0001 returns `(dir & out) | (~dir & 0x17)`.
- R11: A write to 0x0000 or 0x0001 is taken at the clock edge of the write. The next access is decoded with the new mapping.
- R12: `regionSel` is exactly one-hot. Its bits are, from bit 0: port, RAM, BASIC, character, KERNAL, video, sound, color, timer 1, timer 2, open. A cycle with `wrEn` is a write even if `rdEn` is also high, and `rdData` is 0 when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU address |
| wrData | input | 8 | CPU write data |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| ramRdData | input | 8 | Data from RAM |
| basicRdData | input | 8 | Data from BASIC ROM |
| kernalRdData | input | 8 | Data from KERNAL ROM |
| charRdData | input | 8 | Data from character ROM |
| videoRdData | input | 8 | Data from video device |
| soundRdData | input | 8 | Data from sound device |
| colorRdData | input | 4 | Data from color memory |
| timer1RdData | input | 8 | Data from timer 1 |
| timer2RdData | input | 8 | Data from timer 2 |
| floatData | input | 8 | Value used for undefined bus bits |
| regionSel | output | 11 | One-hot decoded region |
| ramCs | output | 1 | RAM select |
| basicCs | output | 1 | BASIC ROM select |
| kernalCs | output | 1 | KERNAL ROM select |
| charCs | output | 1 | Character ROM select |
| videoCs | output | 1 | Video device select |
| soundCs | output | 1 | Sound device select |
| colorCs | output | 1 | Color memory select |
| timer1Cs | output | 1 | Timer 1 select |
| timer2Cs | output | 1 | Timer 2 select |
| romOffset | output | 13 | Masked ROM offset |
| devOffset | output | 6 | Masked peripheral register offset |
| colorOffset | output | 10 | Color memory offset |
| colorWrData | output | 4 | Color memory write nibble |
| rdData | output | 8 | Read data to the CPU |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, reset toggle byte 0x55 and pin pull value 0x17. With these values the mapping space is small enough to cover completely. For all eight effective port values, the bench drives one address in each of the sixteen 4 KiB windows and checks the region, the read data and the chip selects against a mapping model written from the requirements. A second sweep covers all sixteen I/O sub-windows, checking masked offsets and data steering. Directed sequences cover the toggle byte, the port read formula, writes into ROM windows, and a new mapping taking effect after a port write.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int ADDR_W = 16;
  localparam int NUM_REGIONS = 11;

  typedef enum logic [3:0] {
    RG_PORT   = 4'd0,
    RG_RAM    = 4'd1,
    RG_BASIC  = 4'd2,
    RG_CHAR   = 4'd3,
    RG_KERNAL = 4'd4,
    RG_VIDEO  = 4'd5,
    RG_SOUND  = 4'd6,
    RG_COLOR  = 4'd7,
    RG_TIMER1 = 4'd8,
    RG_TIMER2 = 4'd9,
    RG_OPEN   = 4'd10
  } region_e;

  typedef struct packed {
    logic [NUM_REGIONS-1:0] region;
    logic rd;
    logic wr;
    logic dirWr;
    logic outWr;
    logic toggleStep;
  } strobe_t;
endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   rdEn,
  input  logic                   wrEn,
  input  logic [2:0]             effMap,
  output bank_pkg::strobe_t      strobes,
  output logic [NUM_REGIONS-1:0] regionSel,
  output logic                   ramCs,
  output logic                   basicCs,
  output logic                   kernalCs,
  output logic                   charCs,
  output logic                   videoCs,
  output logic                   soundCs,
  output logic                   colorCs,
  output logic                   timer1Cs,
  output logic                   timer2Cs
);
  localparam int DEV_FIRST = int'(RG_VIDEO);
  localparam int DEV_LAST  = int'(RG_TIMER2);
  localparam int NUM_DEV   = DEV_LAST - DEV_FIRST + 1;

  region_e regionNow;
  logic [3:0] window;
  logic [3:0] subWindow;
  logic romLoLive;
  logic ioOrCharLive;
  logic access;
  logic isRd;
  logic isWr;
  logic romWindow;
  logic [NUM_DEV-1:0] devCs;

  assign window    = addr[ADDR_W-1 -: 4];
  assign subWindow = addr[11:8];
  assign romLoLive    = (effMap[1:0] == 2'b11);
  assign ioOrCharLive = (effMap[1:0] != 2'b00);
  assign isWr   = wrEn;
  assign isRd   = rdEn & ~wrEn;
  assign access = isWr | isRd;

  always_comb begin
    regionNow = RG_RAM;
    if (addr[ADDR_W-1:1] == '0) begin
      regionNow = RG_PORT;
    end else begin
      unique case (window)
        4'hA, 4'hB: regionNow = romLoLive ? RG_BASIC : RG_RAM;
        4'hE, 4'hF: regionNow = effMap[1] ? RG_KERNAL : RG_RAM;
        4'hD: begin
          if (!ioOrCharLive)      regionNow = RG_RAM;
          else if (!effMap[2])    regionNow = RG_CHAR;
          else begin
            unique case (subWindow)
              4'h0, 4'h1, 4'h2, 4'h3: regionNow = RG_VIDEO;
              4'h4, 4'h5, 4'h6, 4'h7: regionNow = RG_SOUND;
              4'h8, 4'h9, 4'hA, 4'hB: regionNow = RG_COLOR;
              4'hC:                   regionNow = RG_TIMER1;
              4'hD:                   regionNow = RG_TIMER2;
              default:                regionNow = RG_OPEN;
            endcase
          end
        end
        default: regionNow = RG_RAM;
      endcase
    end
  end

  always_comb begin
    regionSel = '0;
    regionSel[regionNow] = 1'b1;
  end

  assign romWindow = regionSel[RG_BASIC] | regionSel[RG_CHAR] | regionSel[RG_KERNAL];

  assign ramCs    = access & (regionSel[RG_RAM] | (isWr & romWindow));
  assign basicCs  = isRd & regionSel[RG_BASIC];
  assign kernalCs = isRd & regionSel[RG_KERNAL];
  assign charCs   = isRd & regionSel[RG_CHAR];

  generate
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_devCs
      assign devCs[d] = access & regionSel[DEV_FIRST + d];
    end
  endgenerate

  assign videoCs  = devCs[int'(RG_VIDEO)  - DEV_FIRST];
  assign soundCs  = devCs[int'(RG_SOUND)  - DEV_FIRST];
  assign colorCs  = devCs[int'(RG_COLOR)  - DEV_FIRST];
  assign timer1Cs = devCs[int'(RG_TIMER1) - DEV_FIRST];
  assign timer2Cs = devCs[int'(RG_TIMER2) - DEV_FIRST];

  always_comb begin
    strobes            = '0;
    strobes.region     = regionSel;
    strobes.rd         = isRd;
    strobes.wr         = isWr;
    strobes.dirWr      = isWr & regionSel[RG_PORT] & ~addr[0];
    strobes.outWr      = isWr & regionSel[RG_PORT] &  addr[0];
    strobes.toggleStep = isRd & regionSel[RG_OPEN] & (addr[11:0] == 12'hFFF);
  end

  assert_region_onehot_R12: assert property (@(posedge clk) disable iff (!rstN)
    $countones(regionSel) == 1);
  assert_basic_needs_map_R2: assert property (@(posedge clk) disable iff (!rstN)
    regionSel[RG_BASIC] |-> (effMap[1:0] == 2'b11 && addr[15:13] == 3'b101));
  assert_kernal_needs_map_R3: assert property (@(posedge clk) disable iff (!rstN)
    regionSel[RG_KERNAL] |-> (effMap[1] && addr[15:13] == 3'b111));
  assert_char_needs_map_R4: assert property (@(posedge clk) disable iff (!rstN)
    regionSel[RG_CHAR] |-> (!effMap[2] && effMap[1:0] != 2'b00));
  assert_rom_write_to_ram_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !(basicCs || kernalCs || charCs));
  assert_low_ram_R5: assert property (@(posedge clk) disable iff (!rstN)
    (addr >= 16'h0002 && addr < 16'hA000) |-> regionSel[RG_RAM]);
endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import bank_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          COLOR_W     = 4,
  parameter logic [7:0]  TOGGLE_INIT = 8'h55,
  parameter logic [7:0]  PIN_PULL    = 8'h17
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  input  bank_pkg::strobe_t      strobes,
  input  logic [DATA_W-1:0]      ramRdData,
  input  logic [DATA_W-1:0]      basicRdData,
  input  logic [DATA_W-1:0]      kernalRdData,
  input  logic [DATA_W-1:0]      charRdData,
  input  logic [DATA_W-1:0]      videoRdData,
  input  logic [DATA_W-1:0]      soundRdData,
  input  logic [COLOR_W-1:0]     colorRdData,
  input  logic [DATA_W-1:0]      timer1RdData,
  input  logic [DATA_W-1:0]      timer2RdData,
  input  logic [DATA_W-1:0]      floatData,
  output logic [2:0]             effMap,
  output logic [12:0]            romOffset,
  output logic [5:0]             devOffset,
  output logic [9:0]             colorOffset,
  output logic [COLOR_W-1:0]     colorWrData,
  output logic [DATA_W-1:0]      rdData
);
  localparam logic [5:0] VIDEO_MASK = 6'h3F;
  localparam logic [5:0] SOUND_MASK = 6'h1F;
  localparam logic [5:0] TIMER_MASK = 6'h0F;
  localparam logic [DATA_W-1:0] PULL_W = DATA_W'(PIN_PULL);

  logic [DATA_W-1:0] dirQ, outQ, toggleQ;
  logic [DATA_W-1:0] effFull;
  logic [DATA_W-1:0] portPins;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ    <= '0;
      outQ    <= '0;
      toggleQ <= DATA_W'(TOGGLE_INIT);
    end else begin
      if (strobes.dirWr)      dirQ    <= wrData;
      if (strobes.outWr)      outQ    <= wrData;
      if (strobes.toggleStep) toggleQ <= ~toggleQ;
    end
  end

  assign effFull  = ~dirQ | outQ;
  assign effMap   = effFull[2:0];
  assign portPins = (dirQ & outQ) | (~dirQ & PULL_W);

  always_comb begin
    romOffset = '0;
    if (strobes.region[RG_BASIC] || strobes.region[RG_KERNAL]) romOffset = addr[12:0];
    else if (strobes.region[RG_CHAR])                           romOffset = {1'b0, addr[11:0]};
  end

  always_comb begin
    devOffset = '0;
    if (strobes.region[RG_VIDEO])                                    devOffset = addr[5:0] & VIDEO_MASK;
    else if (strobes.region[RG_SOUND])                               devOffset = addr[5:0] & SOUND_MASK;
    else if (strobes.region[RG_TIMER1] || strobes.region[RG_TIMER2]) devOffset = addr[5:0] & TIMER_MASK;
  end

  assign colorOffset = strobes.region[RG_COLOR] ? addr[9:0] : '0;
  assign colorWrData = wrData[COLOR_W-1:0];

  always_comb begin
    rdData = '0;
    if (strobes.rd) begin
      unique case (1'b1)
        strobes.region[RG_PORT]:   rdData = addr[0] ? portPins : dirQ;
        strobes.region[RG_RAM]:    rdData = ramRdData;
        strobes.region[RG_BASIC]:  rdData = basicRdData;
        strobes.region[RG_CHAR]:   rdData = charRdData;
        strobes.region[RG_KERNAL]: rdData = kernalRdData;
        strobes.region[RG_VIDEO]:  rdData = videoRdData;
        strobes.region[RG_SOUND]:  rdData = soundRdData;
        strobes.region[RG_COLOR]:  rdData = {floatData[DATA_W-1:COLOR_W], colorRdData};
        strobes.region[RG_TIMER1]: rdData = timer1RdData;
        strobes.region[RG_TIMER2]: rdData = timer2RdData;
        strobes.region[RG_OPEN]:   rdData = strobes.toggleStep ? ~toggleQ : floatData;
        default:                   rdData = '0;
      endcase
    end
  end

  assert_reset_clears_port_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dirQ == '0 && outQ == '0 && effMap == 3'b111));
  assert_toggle_flips_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.toggleStep |=> (toggleQ == ~$past(toggleQ)));
  assert_toggle_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.toggleStep |=> $stable(toggleQ));
  assert_port_write_lands_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.outWr |=> (outQ == $past(wrData)));
  assert_idle_bus_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rd |-> (rdData == '0));
endmodule

// File: rtl/port_bank_decoder.sv
module port_bank_decoder
  import bank_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          COLOR_W     = 4,
  parameter logic [7:0]  TOGGLE_INIT = 8'h55,
  parameter logic [7:0]  PIN_PULL    = 8'h17
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [15:0]            addr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   rdEn,
  input  logic                   wrEn,
  input  logic [DATA_W-1:0]      ramRdData,
  input  logic [DATA_W-1:0]      basicRdData,
  input  logic [DATA_W-1:0]      kernalRdData,
  input  logic [DATA_W-1:0]      charRdData,
  input  logic [DATA_W-1:0]      videoRdData,
  input  logic [DATA_W-1:0]      soundRdData,
  input  logic [COLOR_W-1:0]     colorRdData,
  input  logic [DATA_W-1:0]      timer1RdData,
  input  logic [DATA_W-1:0]      timer2RdData,
  input  logic [DATA_W-1:0]      floatData,
  output logic [10:0]            regionSel,
  output logic                   ramCs,
  output logic                   basicCs,
  output logic                   kernalCs,
  output logic                   charCs,
  output logic                   videoCs,
  output logic                   soundCs,
  output logic                   colorCs,
  output logic                   timer1Cs,
  output logic                   timer2Cs,
  output logic [12:0]            romOffset,
  output logic [5:0]             devOffset,
  output logic [9:0]             colorOffset,
  output logic [COLOR_W-1:0]     colorWrData,
  output logic [DATA_W-1:0]      rdData
);
  strobe_t    strobes;
  logic [2:0] effMap;

  bank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .effMap(effMap), .strobes(strobes), .regionSel(regionSel),
    .ramCs(ramCs), .basicCs(basicCs), .kernalCs(kernalCs), .charCs(charCs),
    .videoCs(videoCs), .soundCs(soundCs), .colorCs(colorCs),
    .timer1Cs(timer1Cs), .timer2Cs(timer2Cs)
  );

  bank_datapath #(
    .DATA_W(DATA_W), .COLOR_W(COLOR_W),
    .TOGGLE_INIT(TOGGLE_INIT), .PIN_PULL(PIN_PULL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .strobes(strobes),
    .ramRdData(ramRdData), .basicRdData(basicRdData), .kernalRdData(kernalRdData),
    .charRdData(charRdData), .videoRdData(videoRdData), .soundRdData(soundRdData),
    .colorRdData(colorRdData), .timer1RdData(timer1RdData), .timer2RdData(timer2RdData),
    .floatData(floatData), .effMap(effMap), .romOffset(romOffset),
    .devOffset(devOffset), .colorOffset(colorOffset), .colorWrData(colorWrData),
    .rdData(rdData)
  );
endmodule

// File: tb/port_bank_decoder_bench.sv
module port_bank_decoder_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] ramRdData = 8'h11, basicRdData = 8'h22, kernalRdData = 8'h33;
  logic [7:0] charRdData = 8'h44, videoRdData = 8'h66, soundRdData = 8'h77;
  logic [3:0] colorRdData = 4'hB;
  logic [7:0] timer1RdData = 8'h88, timer2RdData = 8'h99, floatData = 8'hC3;
  logic [10:0] regionSel;
  logic ramCs, basicCs, kernalCs, charCs, videoCs, soundCs, colorCs, timer1Cs, timer2Cs;
  logic [12:0] romOffset;
  logic [5:0]  devOffset;
  logic [9:0]  colorOffset;
  logic [3:0]  colorWrData;
  logic [7:0]  rdData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  port_bank_decoder u_port_bank_decoder (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .rdEn(rdEn), .wrEn(wrEn),
    .ramRdData(ramRdData), .basicRdData(basicRdData), .kernalRdData(kernalRdData),
    .charRdData(charRdData), .videoRdData(videoRdData), .soundRdData(soundRdData),
    .colorRdData(colorRdData), .timer1RdData(timer1RdData), .timer2RdData(timer2RdData),
    .floatData(floatData), .regionSel(regionSel), .ramCs(ramCs), .basicCs(basicCs),
    .kernalCs(kernalCs), .charCs(charCs), .videoCs(videoCs), .soundCs(soundCs),
    .colorCs(colorCs), .timer1Cs(timer1Cs), .timer2Cs(timer2Cs), .romOffset(romOffset),
    .devOffset(devOffset), .colorOffset(colorOffset), .colorWrData(colorWrData),
    .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  // region index per requirement R12 bit order
  function automatic int expRegion(input logic [2:0] m, input logic [15:0] a);
    if (a < 16'h0002) return 0;
    case (a[15:12])
      4'hA, 4'hB: return (m[1:0] == 2'b11) ? 2 : 1;
      4'hE, 4'hF: return m[1] ? 4 : 1;
      4'hD: begin
        if (m[1:0] == 2'b00) return 1;
        if (!m[2]) return 3;
        if (a[11:8] < 4) return 5;
        if (a[11:8] < 8) return 6;
        if (a[11:8] < 12) return 7;
        if (a[11:8] == 12) return 8;
        if (a[11:8] == 13) return 9;
        return 10;
      end
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] expData(input int r);
    case (r)
      1: return ramRdData;
      2: return basicRdData;
      3: return charRdData;
      4: return kernalRdData;
      5: return videoRdData;
      6: return soundRdData;
      7: return {floatData[7:4], colorRdData};
      8: return timer1RdData;
      9: return timer2RdData;
      default: return floatData;
    endcase
  endfunction

  task automatic writeByte(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setMap(input logic [7:0] dir, input logic [7:0] out);
    writeByte(16'h0000, dir);
    writeByte(16'h0001, out);
  endtask

  // drive a read and let combinational outputs settle; rdEn drops on next negedge
  task automatic startRead(input logic [15:0] a);
    @(negedge clk);
    addr = a; rdEn = 1'b1; wrEn = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R10: reset state of port
    startRead(16'h0000);
    check("R1 dir after reset", rdData, 8'h00);
    startRead(16'h0001);
    check("R10 pins after reset", rdData, 8'h17);
    startRead(16'hA123);
    check("R1 basic mapped after reset", regionSel, 11'b1 << 2);
    startRead(16'hD012);
    check("R1 io mapped after reset", regionSel, 11'b1 << 5);
    @(negedge clk); rdEn = 1'b0; #1;
    check("R12 idle bus zero", rdData, 8'h00);

    // Exhaustive mapping sweep: R2 R3 R4 R5 R12
    for (int m = 0; m < 8; m++) begin
      setMap(8'hFF, 8'(m));
      for (int n = 0; n < 16; n++) begin
        logic [15:0] a;
        int r;
        a = {4'(n), 12'h345};
        r = expRegion(3'(m), a);
        startRead(a);
        check("R2 R3 R4 R5 region map", regionSel, 11'b1 << r);
        check("R12 read steering", rdData, expData(r));
        check("R6 rom read select", {basicCs, charCs, kernalCs},
              {r == 2, r == 3, r == 4});
      end
      startRead(16'h0002);
      check("R5 addr 2 is RAM", regionSel, 11'b1 << 1);
      startRead(16'h0001);
      check("R5 addr 1 is port", regionSel, 11'b1 << 0);
    end

    // R7 I/O sub-decode sweep
    setMap(8'hFF, 8'h07);
    for (int s = 0; s < 16; s++) begin
      logic [15:0] a;
      int r;
      logic [5:0] eo;
      a = {4'hD, 4'(s), 8'hA7};
      r = expRegion(3'b111, a);
      eo = (r == 5) ? 6'h27 : (r == 6) ? 6'h07 : (r == 8 || r == 9) ? 6'h07 : 6'h00;
      startRead(a);
      check("R7 io region", regionSel, 11'b1 << r);
      check("R7 device offset", devOffset, eo);
      check("R7 device select", {videoCs, soundCs, colorCs, timer1Cs, timer2Cs},
            {r == 5, r == 6, r == 7, r == 8, r == 9});
      check("R7 io read data", rdData, expData(r));
      if (r == 7) check("R7 color offset", colorOffset, a[9:0]);
    end

    // R8 color read/write
    startRead(16'hDBFE);
    check("R8 color read nibble", rdData, {floatData[7:4], 4'hB});
    @(negedge clk);
    addr = 16'hD812; wrData = 8'h5A; wrEn = 1'b1; rdEn = 1'b0; #1;
    check("R8 color write nibble", colorWrData, 4'hA);
    check("R8 color write select", colorCs, 1'b1);
    @(negedge clk); wrEn = 1'b0;

    // R9 toggle byte
    startRead(16'hDFFF);
    check("R9 first toggle", rdData, 8'hAA);
    startRead(16'hDFFF);
    check("R9 second toggle", rdData, 8'h55);
    startRead(16'hDFFE);
    check("R9 other open addr", rdData, floatData);
    startRead(16'hDEFF);
    check("R9 other open addr 2", rdData, floatData);
    startRead(16'hDFFF);
    check("R9 toggle unchanged by open reads", rdData, 8'hAA);

    // R6 writes into ROM windows
    @(negedge clk); rdEn = 1'b0;
    addr = 16'hA010; wrEn = 1'b1; #1;
    check("R6 basic write goes to ram", {ramCs, basicCs}, 2'b10);
    addr = 16'hF010; #1;
    check("R6 kernal write goes to ram", {ramCs, kernalCs}, 2'b10);
    addr = 16'hB123; rdEn = 1'b1; #1;
    check("R12 write wins over read", {ramCs, basicCs}, 2'b10);
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b0;
    startRead(16'hB123);
    check("R6 basic offset", romOffset, 13'h1123);
    setMap(8'hFF, 8'h03);
    startRead(16'hD9AB);
    check("R6 char offset", romOffset, 13'h09AB);
    @(negedge clk); rdEn = 1'b0;
    addr = 16'hD9AB; wrEn = 1'b1; #1;
    check("R6 char write goes to ram", {ramCs, charCs}, 2'b10);
    @(negedge clk); wrEn = 1'b0;

    // R10 port read formula
    setMap(8'h2C, 8'h91);
    startRead(16'h0000);
    check("R10 dir readback", rdData, 8'h2C);
    startRead(16'h0001);
    check("R10 pin readback", rdData, (8'h2C & 8'h91) | (~8'h2C & 8'h17));

    // R11 mapping changes on the edge of the write; dir 0xFF so out drives map
    setMap(8'hFF, 8'h07);
    @(negedge clk);
    addr = 16'h0001; wrData = 8'h00; wrEn = 1'b1; #1;
    startRead(16'hE000);
    check("R11 new map after write", regionSel, 11'b1 << 1);
    startRead(16'hD000);
    check("R11 d window ram", regionSel, 11'b1 << 1);
    @(negedge clk);
    addr = 16'h0000; wrData = 8'h00; wrEn = 1'b1; rdEn = 1'b0; #1;
    startRead(16'hE000);
    check("R11 inputs read as one", regionSel, 11'b1 << 4);

    @(negedge clk); rdEn = 1'b0;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule